// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block picks one interrupt to service among six sources of a small microcontroller core: a power-fail warning, two external lines, two timer overflows and a serial flag that is the OR of its receive and transmit flags. Time is counted in machine cycles, and a single-clock strobe marks the late sampling phase of each one. On every strobe the raw flags are captured. On the next strobe the captured set is polled: it is masked by the enables and reduced to one winner, using a programmable high/low level per source and a fixed order inside each level.

When the CPU status allows it, the winner's acknowledge starts at the end of the polling cycle. The block then holds a vector request with the winner's index for two machine cycles, which make up the third and fourth acknowledge cycles. Two in-service bits, one for each level, stop equal-level or lower-level requests from nesting. A return-from-interrupt pulse retires the most recent level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the level register reads 0, the vector request is low and both in-service bits are clear.
- R2: The level register can be written on any clock through `prio_we`/`prio_wdata` and reads back on `prio_rd` one clock later. Bit 0 is external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1 and bit 4 serial. A 1 puts the source in the high level.
- R3: Source flags are captured only on the clock where `mc_strobe` is high. A flag that is high only between strobes is never acknowledged.
- R4: Polling uses the flags captured at the previous strobe. A flag present at strobe k starts its acknowledge on the clock edge of strobe k+1, and `vec_req` rises right after that edge.
- R5: Any enabled pending high-level source wins over every low-level source, whatever their fixed order.
- R6: Within one level the winner follows the fixed order power-fail (index 0), external 0 (1), timer 0 (2), external 1 (3), timer 1 (4), serial (5).
- R7: The power-fail warning is always high level.
- R8: A source counts as pending only if `glob_en` is high and its bit of `src_en` (indexed as in R6) is high.
- R9: An acknowledge starts only if `last_cycle` is high and `blk_instr` is low at the polling strobe. Otherwise no acknowledge starts, and the request is polled again at the next strobe if it is still captured.
- R10: An acknowledge sets the in-service bit of the winner's level. A low level in service blocks low winners only. A high level in service blocks every winner. Each `reti_done` pulse clears the higher set in-service bit.
- R11: `vec_req` stays high for exactly two machine cycles, until the second strobe after the start, with a steady `vec_idx` equal to the winner's index. No polling takes place in those two cycles or at the strobe that ends them.
- R12: The serial source is pending when either `ser_rx` or `ser_tx` is captured high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_strobe | input | 1 | Sampling phase of each machine cycle |
| src_req | input | 5 | Raw flags: power-fail, ext 0, timer 0, ext 1, timer 1 (bits 0..4) |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| glob_en | input | 1 | Global enable |
| src_en | input | 6 | Per-source enable, indexed as the vector |
| prio_we | input | 1 | Level register write strobe |
| prio_wdata | input | 5 | Level register write data |
| prio_rd | output | 5 | Level register contents |
| last_cycle | input | 1 | Current cycle is the last of an instruction |
| blk_instr | input | 1 | Current instruction is a return or a write to the enable or level register |
| reti_done | input | 1 | Return-from-interrupt executed (one clock pulse) |
| vec_req | output | 1 | Vector request to the CPU |
| vec_idx | output | 3 | Winning source index |

## Verification
A write to the level register shows on `prio_rd` one clock later. Every other result changes only on a strobe edge. A flag captured at one strobe can raise `vec_req` only after the following strobe edge, and `vec_req` drops after the second strobe edge after that. The bench therefore steps whole machine cycles: it holds each input steady through the cycle, pulses the write and return strobes on the first clock only, and compares outputs on the falling edge after the strobe clock, against a model stepped once per machine cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC  = 6;
    localparam int IDXW  = $clog2(NSRC);
    localparam int PRIOW = NSRC - 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IA3  = 2'd1,
        ST_IA4  = 2'd2
    } ack_state_e;

    typedef struct packed {
        logic            valid;
        logic            high;
        logic [IDXW-1:0] idx;
    } pick_t;
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [N-1:0] raw,
    output logic [N-1:0] latched
);
    always_ff @(posedge clk) begin
        if (rst)
            latched <= '0;
        else if (strobe)
            latched <= raw;
    end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  latched,
    input  logic          glob_en,
    input  logic [N-1:0]  src_en,
    input  logic [N-2:0]  prio,
    output logic          win_valid,
    output logic          win_high,
    output logic [IW-1:0] win_idx
);
    logic [N-1:0] pend, hi_mask, hi_vec, lo_vec;

    function automatic logic [IW-1:0] first_set(input logic [N-1:0] v);
        logic [IW-1:0] r;
        r = '0;
        for (int i = N - 1; i >= 0; i--)
            if (v[i]) r = IW'(i);
        return r;
    endfunction

    always_comb begin
        pend      = latched & src_en & {N{glob_en}};
        hi_mask   = {prio, 1'b1};
        hi_vec    = pend & hi_mask;
        lo_vec    = pend & ~hi_mask;
        win_valid = |pend;
        win_high  = |hi_vec;
        win_idx   = win_high ? first_set(hi_vec) : first_set(lo_vec);
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          win_valid,
    input  logic          win_high,
    input  logic [IW-1:0] win_idx,
    input  logic          last_cycle,
    input  logic          blk_instr,
    input  logic          reti_done,
    output logic          vec_req,
    output logic [IW-1:0] vec_idx,
    output logic [1:0]    in_svc
);
    ack_state_e    st;
    logic          allowed, start;
    logic [1:0]    svc_nxt;

    always_comb begin
        allowed = win_high ? !in_svc[1] : !(in_svc[1] || in_svc[0]);
        start   = strobe && (st == ST_IDLE) && win_valid && last_cycle
                  && !blk_instr && allowed;
        svc_nxt = in_svc;
        if (reti_done) begin
            if (in_svc[1]) svc_nxt[1] = 1'b0;
            else           svc_nxt[0] = 1'b0;
        end
        if (start) begin
            if (win_high) svc_nxt[1] = 1'b1;
            else          svc_nxt[0] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            vec_idx <= '0;
            in_svc  <= '0;
        end else begin
            in_svc <= svc_nxt;
            if (strobe) begin
                unique case (st)
                    ST_IDLE: if (start) begin
                        st      <= ST_IA3;
                        vec_idx <= win_idx;
                    end
                    ST_IA3:  st <= ST_IA4;
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign vec_req = (st != ST_IDLE);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mc_strobe,
    input  logic [NSRC-2:0]  src_req,
    input  logic             ser_rx,
    input  logic             ser_tx,
    input  logic             glob_en,
    input  logic [NSRC-1:0]  src_en,
    input  logic             prio_we,
    input  logic [PRIOW-1:0] prio_wdata,
    output logic [PRIOW-1:0] prio_rd,
    input  logic             last_cycle,
    input  logic             blk_instr,
    input  logic             reti_done,
    output logic             vec_req,
    output logic [IDXW-1:0]  vec_idx
);
    logic [PRIOW-1:0] prio_q;
    logic [NSRC-1:0]  raw, latched;
    pick_t            win;
    logic [1:0]       in_svc;

    always_ff @(posedge clk) begin
        if (rst)          prio_q <= '0;
        else if (prio_we) prio_q <= prio_wdata;
    end
    assign prio_rd = prio_q;

    assign raw = {ser_rx | ser_tx, src_req};

    irq_sampler #(.N(NSRC)) u_sampler (
        .clk(clk), .rst(rst), .strobe(mc_strobe), .raw(raw), .latched(latched)
    );

    irq_resolver #(.N(NSRC), .IW(IDXW)) u_resolver (
        .latched(latched), .glob_en(glob_en), .src_en(src_en), .prio(prio_q),
        .win_valid(win.valid), .win_high(win.high), .win_idx(win.idx)
    );

    irq_ack_fsm #(.IW(IDXW)) u_fsm (
        .clk(clk), .rst(rst), .strobe(mc_strobe),
        .win_valid(win.valid), .win_high(win.high), .win_idx(win.idx),
        .last_cycle(last_cycle), .blk_instr(blk_instr), .reti_done(reti_done),
        .vec_req(vec_req), .vec_idx(vec_idx), .in_svc(in_svc)
    );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mc_strobe,
    input logic [NSRC-2:0]  src_req,
    input logic             ser_rx,
    input logic             ser_tx,
    input logic             glob_en,
    input logic [NSRC-1:0]  src_en,
    input logic             prio_we,
    input logic [PRIOW-1:0] prio_wdata,
    input logic [PRIOW-1:0] prio_rd,
    input logic             last_cycle,
    input logic             blk_instr,
    input logic             reti_done,
    input logic             vec_req,
    input logic [IDXW-1:0]  vec_idx
);
    assert_prio_write_R2: assert property (@(posedge clk) disable iff (rst)
        prio_we |=> prio_rd == $past(prio_wdata));

    assert_prio_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !prio_we |=> $stable(prio_rd));

    assert_start_on_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_req) |-> $past(mc_strobe));

    assert_global_mask_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_req) |-> $past(glob_en));

    assert_cpu_gate_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_req) |-> $past(last_cycle && !blk_instr));

    assert_idx_steady_R11: assert property (@(posedge clk) disable iff (rst)
        (vec_req && $past(vec_req)) |-> $stable(vec_idx));

    assert_end_on_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(vec_req) |-> $past(mc_strobe));

    assert_idx_range_R11: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> (int'(vec_idx) < NSRC));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (.*);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mc_strobe = 1'b0;
    logic [4:0] src_req = '0;
    logic       ser_rx = 1'b0, ser_tx = 1'b0;
    logic       glob_en = 1'b1;
    logic [5:0] src_en = '1;
    logic       prio_we = 1'b0;
    logic [4:0] prio_wdata = '0;
    logic [4:0] prio_rd;
    logic       last_cycle = 1'b1, blk_instr = 1'b0, reti_done = 1'b0;
    logic       vec_req;
    logic [2:0] vec_idx;

    always #2 clk = ~clk;

    irq_prio_ctrl uut (.*);

    int n_vec = 0, n_bad = 0, n_clk = 0;
    string tag = "R1";

    logic [4:0] s_req = '0; logic s_rx = 0, s_tx = 0;
    logic s_we = 0, s_reti = 0; logic [4:0] s_wdata = '0;

    logic [4:0] m_prio = '0; logic [1:0] m_ins = '0;
    int m_st = 0; logic [2:0] m_idx = '0; logic [5:0] m_latch = '0;

    function automatic logic [3:0] pick(input logic [5:0] pend, input logic [4:0] pr);
        for (int i = 0; i < 6; i++)
            if (pend[i] && (i == 0 || pr[i-1])) return {1'b1, 3'(i)};
        for (int i = 0; i < 6; i++)
            if (pend[i]) return {1'b0, 3'(i)};
        return 4'b0111;
    endfunction

    task automatic model_step();
        logic [5:0] pend; logic [3:0] p; logic ok;
        if (s_we) m_prio = s_wdata;
        if (s_reti) begin
            if (m_ins[1]) m_ins[1] = 1'b0; else m_ins[0] = 1'b0;
        end
        if (m_st == 2) m_st = 0;
        else if (m_st == 1) m_st = 2;
        else begin
            pend = m_latch & src_en & {6{glob_en}};
            p = pick(pend, m_prio);
            ok = p[3] ? !m_ins[1] : !(m_ins[1] || m_ins[0]);
            if (pend != 0 && last_cycle && !blk_instr && ok) begin
                m_st = 1; m_idx = p[2:0];
                if (p[3]) m_ins[1] = 1'b1; else m_ins[0] = 1'b1;
            end
        end
        m_latch = {s_rx | s_tx, s_req};
    endtask

    task automatic check(input logic exp_req, input logic [2:0] exp_idx, input logic [4:0] exp_prio);
        n_vec++;
        if (vec_req !== exp_req || (exp_req && vec_idx !== exp_idx) || prio_rd !== exp_prio) begin
            n_bad++;
            $display("FAIL %s: req=%b idx=%0d prio=%b expected req=%b idx=%0d prio=%b",
                     tag, vec_req, vec_idx, prio_rd, exp_req, exp_idx, exp_prio);
        end
    endtask

    // one machine cycle: the strobe is on the fourth clock, the check on the falling edge after it
    task automatic mc(input logic [5:0] glitch = '0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            mc_strobe  = (k == 3);
            src_req    = (k == 3) ? s_req : (s_req | glitch[4:0]);
            ser_rx     = (k == 3) ? s_rx : (s_rx | glitch[5]);
            ser_tx     = s_tx;
            prio_we    = (k == 0) && s_we;
            prio_wdata = s_wdata;
            reti_done  = (k == 0) && s_reti;
            @(posedge clk);
        end
        @(negedge clk);
        mc_strobe = 1'b0;
        model_step();
        s_we = 1'b0; s_reti = 1'b0;
        check(m_st != 0, m_idx, m_prio);
    endtask

    task automatic set_prio(input logic [4:0] v);
        s_we = 1'b1; s_wdata = v; mc();
    endtask

    task automatic drain();
        s_req = '0; s_rx = 0; s_tx = 0;
        repeat (3) mc();
        s_reti = 1'b1; mc();
        s_reti = 1'b1; mc();
    endtask

    initial begin
        forever begin
            @(posedge clk); n_clk++;
            if (n_clk > 150000) begin
                n_bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        tag = "R1"; check(1'b0, 3'd0, 5'd0);

        tag = "R2"; set_prio(5'b10101); set_prio(5'b01010); set_prio(5'b00000);

        tag = "R4";  // flag at one strobe, acknowledge after the next
        s_req = 5'b01000; mc(); s_req = '0; mc(); mc(); mc(); drain();

        tag = "R6";
        s_req = 5'b11010; mc(); mc(); drain();

        tag = "R5"; set_prio(5'b01000);
        s_req = 5'b10010; mc(); mc(); drain();

        tag = "R7"; set_prio(5'b11111);
        s_req = 5'b00011; mc(); mc(); drain();

        tag = "R12"; set_prio(5'b00000);
        s_tx = 1; mc(); mc(); drain();
        s_rx = 1; mc(); mc(); drain();

        tag = "R8";
        glob_en = 0; s_req = 5'b00100; repeat (4) mc(); glob_en = 1; mc(); mc(); drain();
        src_en = 6'b111101; s_req = 5'b00010; repeat (4) mc(); src_en = '1; mc(); mc(); drain();

        tag = "R9";
        last_cycle = 0; s_req = 5'b10000; repeat (3) mc();
        last_cycle = 1; blk_instr = 1; repeat (3) mc();
        blk_instr = 0; mc(); mc(); drain();

        tag = "R10"; set_prio(5'b00010);
        s_req = 5'b00010; mc(); mc(); s_req = '0; repeat (3) mc();
        s_req = 5'b01000; repeat (3) mc();
        s_req = 5'b01100; repeat (4) mc();
        s_req = 5'b00001; repeat (4) mc();
        s_req = 5'b00000; s_reti = 1; mc(); repeat (2) mc();
        s_reti = 1; mc(); s_req = 5'b01000; repeat (4) mc(); drain();

        tag = "R3"; set_prio(5'b00000);
        repeat (4) mc(6'b111111); drain();

        tag = "R11";
        void'($urandom(32'h1a2b3c4d));
        for (int i = 0; i < 1200; i++) begin
            s_req      = 5'($urandom & $urandom & $urandom);
            s_rx       = ($urandom % 8) == 0;
            s_tx       = ($urandom % 8) == 0;
            glob_en    = ($urandom % 10) != 0;
            src_en     = (($urandom % 4) == 0) ? 6'($urandom) : 6'h3f;
            last_cycle = ($urandom % 4) != 0;
            blk_instr  = ($urandom % 7) == 0;
            s_reti     = ($urandom % 6) == 0;
            s_we       = ($urandom % 7) == 0;
            s_wdata    = 5'($urandom);
            mc(6'($urandom & $urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule